// File: doc/BRIEF.md
# Thermometer-to-Code Packer with Oversampling Modes

This block sits behind four fine time-measurement units. Each unit delivers a 16-bit comparator word per measurement. The block turns each word into a step count by counting the ones in it. It then combines those counts according to one of three oversampling modes and sends the resulting codes out on two pins: a serial data line and a per-sample strobe.

In the four-times mode, each unit measures a different phase of the reference cycle, so four independent codes leave for every measurement. In the two-times mode, units 0 and 1 form one two-stage chain and units 2 and 3 form another, giving two codes with twice the range. In the one-times mode, all four units form a single chain, giving one code with four times the range of a single unit.

A measurement is accepted only while the serializer is idle. The mode applies to a measurement from the cycle in which that measurement is captured.

Top module: `jitter_code_packer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no capture, `ser_data` and `ser_frame` are both 0.
- R2: A unit's count is the number of ones anywhere in its 16-bit word. Unit k occupies `cmp_bits[16k+15:16k]`. A pattern with gaps (bubbles) gives its plain ones total.
- R3: With `mode_sel` = 2'b00 (four-times), one frame carries four 7-bit codes. Each code is one unit's count, sent in unit order 0, 1, 2, 3.
- R4: With `mode_sel` = 2'b01 (two-times), one frame carries two codes, for the unit pairs (0,1) and (2,3) in that order. A pair code is the first unit's count if that unit is not saturated. Otherwise it is 16 plus the second unit's count. A unit is saturated when its count is 16.
- R5: With `mode_sel` = 2'b10 or 2'b11 (one-times), one frame carries one code. Take the lowest-index unit whose count is below 16, call its index k and its count c. The code is 16·k + c.
- R6: When every unit of a chain is saturated, the code is 16 times the chain length. In the one-times mode this is 64, so bit 6 of the code acts as the overflow flag. In the two-times mode it is 32.
- R7: Every code is 7 bits, sent MSB first at one bit per clock. The first bit appears in the cycle after the capture edge. `ser_frame` is 1 exactly on the first bit of each code.
- R8: A `cmp_valid` pulse that arrives while a frame is still being sent is ignored. The frame in progress continues unchanged and the pulse does not start a new frame.
- R9: `mode_sel` is sampled only at capture. A change during a frame does not alter the length or content of that frame.
- R10: Between frames, `ser_data` and `ser_frame` are 0. A frame starts on the first clock edge where `cmp_valid` is 1 and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Oversampling mode: 00 four-times, 01 two-times, 1x one-times |
| cmp_valid | input | 1 | A measurement is present on `cmp_bits` |
| cmp_bits | input | 64 | Comparator words of the four units, unit 0 in the low 16 bits |
| ser_data | output | 1 | Serial code bits, MSB first |
| ser_frame | output | 1 | High on the first bit of each code |

## Verification
Every code bit leaves the block exactly once, in a fixed cycle after capture. A miscounted unit or a wrong choice of chain link therefore shows up as a wrong bit within seven clocks of the frame start. A wrong bit-position counter or frame-length counter moves the strobe, or makes the frame longer or shorter than expected. That shows at the ports no later than the idle check that follows the frame. A capture that was wrongly accepted mid-frame shows as extra bits or strobes in the cycles where both lines should already be low.

// File: rtl/jcp_pkg.sv
package jcp_pkg;
  typedef enum logic [1:0] {
    MODE_X4  = 2'b00,
    MODE_X2  = 2'b01,
    MODE_X1  = 2'b10,
    MODE_X1B = 2'b11
  } os_mode_e;
endpackage

// File: rtl/ones_counter.sv
module ones_counter #(
  parameter int BITS  = 16,
  localparam int CNT_W = $clog2(BITS + 1)
) (
  input  logic [BITS-1:0]  therm,
  output logic [CNT_W-1:0] count,
  output logic             sat
);
  // Population count: a bubble inside the thermometer word costs one step,
  // never a gross error.
  function automatic logic [CNT_W-1:0] popcount(input logic [BITS-1:0] w);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < BITS; i++) acc = acc + CNT_W'(w[i]);
    return acc;
  endfunction

  assign count = popcount(therm);
  assign sat   = (count == CNT_W'(BITS));
endmodule

// File: rtl/mode_combiner.sv
module mode_combiner
  import jcp_pkg::*;
#(
  parameter int UNITS = 4,
  parameter int BITS  = 16,
  localparam int CNT_W  = $clog2(BITS + 1),
  localparam int CODE_W = $clog2(UNITS * BITS + 1),
  localparam int NS_W   = $clog2(UNITS + 1)
) (
  input  os_mode_e                  mode,
  input  logic [UNITS*CNT_W-1:0]    counts,
  input  logic [UNITS-1:0]          sats,
  output logic [UNITS*CODE_W-1:0]   codes,     // sample 0 in the top slot
  output logic [NS_W-1:0]           n_samples
);
  // A chain of len units starting at unit start. The code is BITS times the
  // index of the first unsaturated link plus that link's count. If every
  // link is saturated, the code is BITS*len.
  function automatic int chain_code(input int start, input int len,
                                    input logic [UNITS*CNT_W-1:0] cnt,
                                    input logic [UNITS-1:0] sat);
    int  res;
    bit  found;
    res   = BITS * len;
    found = 1'b0;
    for (int k = 0; k < UNITS; k++) begin
      if (k < len && !found && (start + k) < UNITS) begin
        if (!sat[start + k]) begin
          res   = BITS * k + int'(cnt[(start + k) * CNT_W +: CNT_W]);
          found = 1'b1;
        end
      end
    end
    return res;
  endfunction

  int glen;

  always_comb begin
    case (mode)
      MODE_X4: begin glen = 1;         n_samples = NS_W'(UNITS);     end
      MODE_X2: begin glen = 2;         n_samples = NS_W'(UNITS / 2); end
      default: begin glen = UNITS;     n_samples = NS_W'(1);         end
    endcase
    codes = '0;
    for (int s = 0; s < UNITS; s++) begin
      if (s < int'(n_samples))
        codes[(UNITS - s) * CODE_W - 1 -: CODE_W] =
          CODE_W'(chain_code(s * glen, glen, counts, sats));
    end
  end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int UNITS  = 4,
  parameter int CODE_W = 7,
  localparam int FRAME_W = UNITS * CODE_W,
  localparam int LEFT_W  = $clog2(FRAME_W + 1),
  localparam int POS_W   = $clog2(CODE_W),
  localparam int NS_W    = $clog2(UNITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] codes,
  input  logic [NS_W-1:0]    n_samples,
  output logic               ser_data,
  output logic               ser_frame,
  output logic               busy,
  output logic [LEFT_W-1:0]  bits_left
);
  logic [FRAME_W-1:0] shreg;
  logic [POS_W-1:0]   pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      bits_left <= '0;
      pos       <= '0;
    end else if (load) begin
      shreg     <= codes;
      bits_left <= LEFT_W'(int'(n_samples) * CODE_W);
      pos       <= '0;
    end else if (bits_left != '0) begin
      shreg     <= shreg << 1;
      bits_left <= bits_left - LEFT_W'(1);
      pos       <= (pos == POS_W'(CODE_W - 1)) ? '0 : pos + POS_W'(1);
    end
  end

  assign busy      = (bits_left != '0);
  assign ser_data  = busy & shreg[FRAME_W-1];
  assign ser_frame = busy & (pos == '0);
endmodule

// File: rtl/jitter_code_packer.sv
module jitter_code_packer
  import jcp_pkg::*;
#(
  parameter int UNITS = 4,
  parameter int BITS  = 16,
  localparam int CNT_W   = $clog2(BITS + 1),
  localparam int CODE_W  = $clog2(UNITS * BITS + 1),
  localparam int NS_W    = $clog2(UNITS + 1),
  localparam int FRAME_W = UNITS * CODE_W,
  localparam int LEFT_W  = $clog2(FRAME_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode_sel,
  input  logic                  cmp_valid,
  input  logic [UNITS*BITS-1:0] cmp_bits,
  output logic                  ser_data,
  output logic                  ser_frame
);
  logic [UNITS*CNT_W-1:0] counts;
  logic [UNITS-1:0]       sats;
  logic [FRAME_W-1:0]     codes;
  logic [NS_W-1:0]        n_samples;
  logic                   busy;
  logic                   load;
  logic [LEFT_W-1:0]      bits_left;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    ones_counter #(.BITS(BITS)) u_cnt (
      .therm (cmp_bits[u*BITS +: BITS]),
      .count (counts[u*CNT_W +: CNT_W]),
      .sat   (sats[u])
    );
  end

  mode_combiner #(.UNITS(UNITS), .BITS(BITS)) u_comb (
    .mode      (os_mode_e'(mode_sel)),
    .counts    (counts),
    .sats      (sats),
    .codes     (codes),
    .n_samples (n_samples)
  );

  // A capture is taken only at a frame boundary; that edge fixes mode and data.
  assign load = cmp_valid & ~busy;

  frame_serializer #(.UNITS(UNITS), .CODE_W(CODE_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .codes     (codes),
    .n_samples (n_samples),
    .ser_data  (ser_data),
    .ser_frame (ser_frame),
    .busy      (busy),
    .bits_left (bits_left)
  );
endmodule

// File: rtl/jcp_checker.sv
module jcp_checker #(
  parameter int UNITS  = 4,
  parameter int BITS   = 16,
  parameter int CODE_W = 7,
  parameter int LEFT_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ser_data,
  input logic                     ser_frame,
  input logic                     busy,
  input logic                     load,
  input logic [LEFT_W-1:0]        bits_left,
  input logic [UNITS*CODE_W-1:0]  codes
);
  // R7: a strobe never lasts two cycles, because every code is wider than one bit
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    ser_frame |=> !ser_frame);

  // R7: the first bit after a capture carries the strobe
  a_r7_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ser_frame);

  // R10: lines are quiet while no frame is in progress
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_data && !ser_frame));

  // R8: once a frame is running, it only counts down, whatever cmp_valid does
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left > LEFT_W'(1)) |=> (bits_left == $past(bits_left) - LEFT_W'(1)));

  // R6: no code exceeds the full chained range
  always_comb begin
    if (rst_n) begin
      for (int s = 0; s < UNITS; s++)
        a_r6_code_range: assert (int'(codes[s*CODE_W +: CODE_W]) <= UNITS * BITS);
    end
  end
endmodule

bind jitter_code_packer jcp_checker #(
  .UNITS(UNITS), .BITS(BITS), .CODE_W(CODE_W), .LEFT_W(LEFT_W)
) u_jcp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_data  (ser_data),
  .ser_frame (ser_frame),
  .busy      (busy),
  .load      (load),
  .bits_left (bits_left),
  .codes     (codes)
);

// File: tb/test_jitter_code_packer.sv
`timescale 1ns/1ps
module test_jitter_code_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        cmp_valid;
  logic [63:0] cmp_bits;
  logic        ser_data;
  logic        ser_frame;
  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  jitter_code_packer i_jitter_code_packer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cmp_valid(cmp_valid),
    .cmp_bits(cmp_bits), .ser_data(ser_data), .ser_frame(ser_frame)
  );

  localparam int NV = 9;
  localparam logic [1:0]  V_MODE [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10,
                                          2'b10, 2'b10, 2'b10, 2'b11};
  localparam logic [63:0] V_BITS [NV] = '{
    64'h0007_FFFF_0000_00FF,  // R3: 8,0,16,3
    64'h0001_7FFF_0005_00F7,  // R2 bubbles: 7,2,15,1
    64'hFFFF_0FFF_003F_FFFF,  // R4: 16+6, 12
    64'hFFFF_FFFF_FFFF_FFFF,  // R6 two-times: 32,32
    64'h0000_01FF_FFFF_FFFF,  // R5: 32+9
    64'hFFFF_FFFF_FFFF_0003,  // R5: unit 0 not saturated
    64'hFFFF_FFFF_FFFF_FFFF,  // R6 overflow: 64
    64'h7FFF_FFFF_FFFF_FFFF,  // R5: 48+15
    64'h0000_0000_000F_FFFF   // R5 mode 11: 16+4
  };
  localparam int V_NS [NV] = '{4, 4, 2, 2, 1, 1, 1, 1, 1};
  localparam logic [27:0] V_EXP [NV] = '{
    {7'd8,  7'd0,  7'd16, 7'd3},
    {7'd7,  7'd2,  7'd15, 7'd1},
    {7'd22, 7'd12, 7'd0,  7'd0},
    {7'd32, 7'd32, 7'd0,  7'd0},
    {7'd41, 7'd0,  7'd0,  7'd0},
    {7'd2,  7'd0,  7'd0,  7'd0},
    {7'd64, 7'd0,  7'd0,  7'd0},
    {7'd63, 7'd0,  7'd0,  7'd0},
    {7'd20, 7'd0,  7'd0,  7'd0}
  };
  localparam string V_REQ [NV] = '{"R3", "R2", "R4", "R6", "R5",
                                   "R5", "R6", "R5", "R5"};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge with the design idle. poke >= 0 raises cmp_valid with
  // different data and mode in that bit slot of the frame.
  task automatic run_frame(input logic [1:0] m, input logic [63:0] bits,
                           input int ns, input logic [27:0] exp,
                           input string req, input int poke);
    mode_sel  = m;
    cmp_bits  = bits;
    cmp_valid = 1'b1;
    @(negedge clk);
    for (int s = 0; s < ns; s++) begin
      for (int b = 0; b < 7; b++) begin
        chk(req, int'(ser_data), int'(exp[27 - s*7 - b]));
        chk("R7", int'(ser_frame), (b == 0) ? 1 : 0);
        if (s*7 + b == poke) begin
          cmp_valid = 1'b1;
          mode_sel  = ~m;
          cmp_bits  = ~bits;
        end else begin
          cmp_valid = 1'b0;
        end
        @(negedge clk);
      end
    end
    cmp_valid = 1'b0;
    mode_sel  = m;
    chk("R10", int'({ser_data, ser_frame}), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    mode_sel  = 2'b00;
    cmp_valid = 1'b0;
    cmp_bits  = '0;
    repeat (3) @(negedge clk);
    chk("R1", int'({ser_data, ser_frame}), 0);
    cmp_valid = 1'b1;
    cmp_bits  = '1;
    @(negedge clk);
    chk("R1", int'({ser_data, ser_frame}), 0);  // valid in reset is not taken
    cmp_valid = 1'b0;
    rst_n     = 1'b1;
    @(negedge clk);
    chk("R1", int'({ser_data, ser_frame}), 0);

    for (int v = 0; v < NV; v++)
      run_frame(V_MODE[v], V_BITS[v], V_NS[v], V_EXP[v], V_REQ[v], -1);

    // R8: pulse mid-frame in four-times mode is ignored
    run_frame(2'b00, V_BITS[0], 4, V_EXP[0], "R8", 10);
    // R8: pulse on the very last bit is ignored
    run_frame(2'b01, V_BITS[2], 2, V_EXP[2], "R8", 13);
    // R9: mode flips to two-times mid-frame; the one-times frame stays 7 bits
    run_frame(2'b10, V_BITS[4], 1, V_EXP[4], "R9", 3);
    // R9: the new mode applies from the next capture
    run_frame(2'b01, V_BITS[4], 2, {7'd32, 7'd9, 14'd0}, "R9", -1);
    // R10: idle stays quiet without cmp_valid
    repeat (3) begin
      @(negedge clk);
      chk("R10", int'({ser_data, ser_frame}), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule